// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept, based on its 48-bit destination address and its length. The receive path presents the destination address and the frame length together with a one-cycle strobe. One clock later the block returns a registered accept decision and the raw result of the address filter, marked by a one-cycle valid pulse. Strobes may arrive on every cycle.

The filter behaviour comes from a 32-bit control word, which is loaded through a load strobe and reset to a promiscuous, receive-disabled state. The control word selects among several options:

- promiscuous reception
- rejection of broadcasts
- acceptance of all group addresses
- exact comparison against the station address, with optional inversion
- a 64-bin hash filter driven by the CRC-32 of the address

The choice between exact match and hash is made separately for individual (unicast) and group (multicast) destinations. A receive-all option keeps frames that fail the filter.

Byte packing: byte k of an address, in wire order, sits at bits [8k+7:8k], so the first byte received is bits [7:0].

Top module: `eth_dest_filter`

## Requirements
- R1: For each cycle with `addrValid` high, `acceptValid` is high for exactly one cycle, on the next clock, carrying `accept` and `filterPass` for that strobe. `acceptValid` is low in all other cycles.
- R2: Reset leaves `acceptValid` and `accept` low and sets the control word to 0x0004_0000, which is promiscuous on and receive-enable off. Frames after reset are therefore rejected, while `filterPass` reads 1.
- R3: While control bit 2 (receive enable) is 0, every frame is rejected, even when bit 31 or bit 18 is set.
- R4: A frame whose length is below 14 or at least 2048 bytes is rejected whatever the filter result is. Lengths of 14 and 2047 are allowed.
- R5: With control bit 18 (promiscuous) set, the filter passes every destination.
- R6: An all-ones destination is a broadcast. It passes unless control bit 11 is set. This holds even when bit 19 is set or a hash or exact match would pass it.
- R7: A destination is multicast when bit 0 of its first byte is 1. With control bit 19 set, every non-broadcast multicast destination passes.
- R8: Exact comparison with `stationAddr` is used for unicast destinations when control bit 15 is 0, and for multicast destinations when control bit 13 is 0. Each class follows only its own bit.
- R9: Control bit 17 inverts the outcome of an exact comparison. It has no effect on the hash outcome.
- R10: In hash mode the bin is bits [31:26] of a CRC-32 computed over the six address bytes, first byte first and each byte LSB first. The CRC uses polynomial 0x04C11DB7, starts at all ones, and has no final inversion. Bin bit 5 selects `hashHi` (1) or `hashLo` (0), and bits [4:0] select the bit within that register. The frame passes if that bit is 1.
- R11: With control bit 31 (receive all) set, a frame that fails the filter is still accepted, and `filterPass` reports 0 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlLoad | input | 1 | Load `ctrlIn` into the control word |
| ctrlIn | input | 32 | New control word value |
| stationAddr | input | 48 | Own station address, byte 0 in bits [7:0] |
| hashHi | input | 32 | Hash bins 32..63 |
| hashLo | input | 32 | Hash bins 0..31 |
| addrValid | input | 1 | Destination and length are valid this cycle |
| destAddr | input | 48 | Destination address, byte 0 in bits [7:0] |
| frameLen | input | 16 | Frame length in bytes |
| acceptValid | output | 1 | Decision valid, one cycle after `addrValid` |
| accept | output | 1 | Frame is kept |
| filterPass | output | 1 | Address filter result before receive-all, length and enable gating |

## Verification
Every decision is due exactly one clock after its strobe. A control word load takes effect on the cycle after the load strobe, and the station and hash inputs are used in the strobe cycle itself. The driver applies strobes at the falling edge and queues the expected outputs, which come from a model of the requirements. The monitor samples a quarter period after each rising edge and pops one entry for every `acceptValid` it sees. A result with nothing queued, or entries left over at the end, is reported against R1.

// File: rtl/edf_pkg.sv
package edf_pkg;

  // control word bit positions
  localparam int unsigned CtlRxEn     = 2;
  localparam int unsigned CtlBcastDis = 11;
  localparam int unsigned CtlHashMc   = 13;
  localparam int unsigned CtlHashUc   = 15;
  localparam int unsigned CtlInvert   = 17;
  localparam int unsigned CtlPromisc  = 18;
  localparam int unsigned CtlMcPass   = 19;
  localparam int unsigned CtlRxAll    = 31;

  localparam logic [31:0] CtlResetVal = 32'h0004_0000;
  localparam logic [31:0] CrcPoly     = 32'h04C1_1DB7;

  // classification results handed from datapath to control
  typedef struct packed {
    logic isBcast;
    logic isMcast;
    logic exactHit;
    logic hashHit;
    logic lenOk;
  } addrClass_t;

  // decoded control flags
  typedef struct packed {
    logic rxEn;
    logic bcastDis;
    logic hashMc;
    logic hashUc;
    logic invert;
    logic promisc;
    logic mcPass;
    logic rxAll;
  } ctlFlags_t;

endpackage

// File: rtl/edf_crc.sv
module edf_crc #(
  parameter int unsigned NUM_BYTES = 6
) (
  input  logic [8*NUM_BYTES-1:0] dataIn,
  output logic [31:0]            crcOut
);
  import edf_pkg::*;

  function automatic logic [31:0] byteStep(input logic [31:0] crcIn, input logic [7:0] b);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ b[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CrcPoly;
    end
    return c;
  endfunction

  logic [31:0] stage [NUM_BYTES+1];
  assign stage[0] = 32'hFFFF_FFFF;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    assign stage[k+1] = byteStep(stage[k], dataIn[8*k +: 8]);
  end

  assign crcOut = stage[NUM_BYTES];

endmodule

// File: rtl/edf_datapath.sv
module edf_datapath #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned MIN_LEN    = 14,
  parameter int unsigned MAX_LEN    = 2048,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic [8*ADDR_BYTES-1:0]        destAddr,
  input  logic [8*ADDR_BYTES-1:0]        stationAddr,
  input  logic [2**(HASH_BITS-1)-1:0]    hashHi,
  input  logic [2**(HASH_BITS-1)-1:0]    hashLo,
  input  logic [LEN_W-1:0]               frameLen,
  output edf_pkg::addrClass_t            addrClass
);
  import edf_pkg::*;

  localparam int unsigned AddrW = 8 * ADDR_BYTES;
  localparam int unsigned SelW  = HASH_BITS - 1;

  logic [ADDR_BYTES-1:0] byteEq;
  logic [ADDR_BYTES-1:0] byteOnes;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
    assign byteEq[k]   = (destAddr[8*k +: 8] == stationAddr[8*k +: 8]);
    assign byteOnes[k] = &destAddr[8*k +: 8];
  end

  logic [31:0] crcFull;
  edf_crc #(.NUM_BYTES(ADDR_BYTES)) u_crc (
    .dataIn (destAddr),
    .crcOut (crcFull)
  );

  logic [HASH_BITS-1:0] hashIdx;
  logic [SelW-1:0]      bitSel;
  logic                 unusedCrcLow;
  assign hashIdx      = crcFull[31 -: HASH_BITS];
  assign bitSel       = hashIdx[SelW-1:0];
  assign unusedCrcLow = ^crcFull[31-HASH_BITS:0];

  logic hashBit;
  always_comb begin
    if (hashIdx[HASH_BITS-1]) hashBit = hashHi[bitSel];
    else                      hashBit = hashLo[bitSel];
  end

  logic lenOk;
  assign lenOk = (frameLen >= LEN_W'(MIN_LEN)) && (frameLen < LEN_W'(MAX_LEN));

  always_comb begin
    addrClass.isBcast  = &byteOnes;
    addrClass.isMcast  = destAddr[0];
    addrClass.exactHit = &byteEq;
    addrClass.hashHit  = hashBit;
    addrClass.lenOk    = lenOk;
  end

  logic unusedWidth;
  assign unusedWidth = (AddrW == 0);

endmodule

// File: rtl/edf_control.sv
module edf_control (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlLoad,
  input  logic [31:0]         ctrlIn,
  input  logic                addrValid,
  input  edf_pkg::addrClass_t addrClass,
  output logic                acceptValid,
  output logic                accept,
  output logic                filterPass
);
  import edf_pkg::*;

  logic [31:0] ctrlQ;

  always_ff @(posedge clk) begin
    if (!rstN)         ctrlQ <= CtlResetVal;
    else if (ctrlLoad) ctrlQ <= ctrlIn;
  end

  ctlFlags_t flags;
  always_comb begin
    flags.rxEn     = ctrlQ[CtlRxEn];
    flags.bcastDis = ctrlQ[CtlBcastDis];
    flags.hashMc   = ctrlQ[CtlHashMc];
    flags.hashUc   = ctrlQ[CtlHashUc];
    flags.invert   = ctrlQ[CtlInvert];
    flags.promisc  = ctrlQ[CtlPromisc];
    flags.mcPass   = ctrlQ[CtlMcPass];
    flags.rxAll    = ctrlQ[CtlRxAll];
  end

  logic useExact;
  logic passNow;
  logic acceptNow;

  // fixed priority: promiscuous, broadcast, multicast pass-all, exact/hash
  always_comb begin
    useExact = addrClass.isMcast ? !flags.hashMc : !flags.hashUc;
    if (flags.promisc)                           passNow = 1'b1;
    else if (addrClass.isBcast)                  passNow = !flags.bcastDis;
    else if (addrClass.isMcast && flags.mcPass)  passNow = 1'b1;
    else if (useExact)                           passNow = addrClass.exactHit ^ flags.invert;
    else                                         passNow = addrClass.hashHit;
    acceptNow = flags.rxEn && addrClass.lenOk && (passNow || flags.rxAll);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptValid <= 1'b0;
      accept      <= 1'b0;
      filterPass  <= 1'b0;
    end else begin
      acceptValid <= addrValid;
      accept      <= addrValid && acceptNow;
      filterPass  <= addrValid && passNow;
    end
  end

  // R1
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> acceptValid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !acceptValid);
  // R3
  rx_disabled_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !ctrlQ[CtlRxEn]) |=> !accept);
  // R4
  bad_length_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrClass.lenOk) |=> !accept);
  // R5
  promisc_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && ctrlQ[CtlPromisc]) |=> filterPass);
  // R11
  rx_all_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && ctrlQ[CtlRxAll] && ctrlQ[CtlRxEn] && addrClass.lenOk) |=> accept);

endmodule

// File: rtl/eth_dest_filter.sv
module eth_dest_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned MIN_LEN    = 14,
  parameter int unsigned MAX_LEN    = 2048,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ctrlLoad,
  input  logic [31:0]                   ctrlIn,
  input  logic [8*ADDR_BYTES-1:0]       stationAddr,
  input  logic [2**(HASH_BITS-1)-1:0]   hashHi,
  input  logic [2**(HASH_BITS-1)-1:0]   hashLo,
  input  logic                          addrValid,
  input  logic [8*ADDR_BYTES-1:0]       destAddr,
  input  logic [LEN_W-1:0]              frameLen,
  output logic                          acceptValid,
  output logic                          accept,
  output logic                          filterPass
);
  import edf_pkg::*;

  addrClass_t addrClass;

  edf_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .LEN_W      (LEN_W),
    .MIN_LEN    (MIN_LEN),
    .MAX_LEN    (MAX_LEN),
    .HASH_BITS  (HASH_BITS)
  ) u_datapath (
    .destAddr    (destAddr),
    .stationAddr (stationAddr),
    .hashHi      (hashHi),
    .hashLo      (hashLo),
    .frameLen    (frameLen),
    .addrClass   (addrClass)
  );

  edf_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlLoad    (ctrlLoad),
    .ctrlIn      (ctrlIn),
    .addrValid   (addrValid),
    .addrClass   (addrClass),
    .acceptValid (acceptValid),
    .accept      (accept),
    .filterPass  (filterPass)
  );

endmodule

// File: tb/test_eth_dest_filter.sv
module test_eth_dest_filter;
  localparam time ClkPeriod = 10ns;

  localparam logic [31:0] BRxEn   = 32'h1 << 2;
  localparam logic [31:0] BBcDis  = 32'h1 << 11;
  localparam logic [31:0] BHashMc = 32'h1 << 13;
  localparam logic [31:0] BHashUc = 32'h1 << 15;
  localparam logic [31:0] BInv    = 32'h1 << 17;
  localparam logic [31:0] BProm   = 32'h1 << 18;
  localparam logic [31:0] BMcPass = 32'h1 << 19;
  localparam logic [31:0] BRxAll  = 32'h1 << 31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlLoad = 1'b0;
  logic [31:0] ctrlIn = '0;
  logic [47:0] stationAddr = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  logic [31:0] hashHi = '0;
  logic [31:0] hashLo = '0;
  logic        addrValid = 1'b0;
  logic [47:0] destAddr = '0;
  logic [15:0] frameLen = '0;
  logic        acceptValid, accept, filterPass;

  always #(ClkPeriod/2) clk = ~clk;

  eth_dest_filter i_eth_dest_filter (
    .clk, .rstN, .ctrlLoad, .ctrlIn, .stationAddr, .hashHi, .hashLo,
    .addrValid, .destAddr, .frameLen, .acceptValid, .accept, .filterPass
  );

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int seen = 0;
  logic [31:0] ctrlModel = 32'h0004_0000;

  logic  qAcc [$];
  logic  qPass [$];
  string qTag [$];

  function automatic logic [5:0] benchHash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [1:0] model(input logic [47:0] d, input logic [15:0] len);
    logic p, a, exact, mc;
    mc = d[0];
    exact = mc ? !ctrlModel[13] : !ctrlModel[15];
    if (ctrlModel[18]) p = 1'b1;
    else if (d == '1) p = !ctrlModel[11];
    else if (mc && ctrlModel[19]) p = 1'b1;
    else if (exact) p = (d == stationAddr) ^ ctrlModel[17];
    else begin
      logic [5:0] h;
      h = benchHash(d);
      p = h[5] ? hashHi[h[4:0]] : hashLo[h[4:0]];
    end
    a = ctrlModel[2] && len >= 14 && len < 2048 && (p || ctrlModel[31]);
    return {a, p};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic loadCtrl(input logic [31:0] v);
    @(negedge clk);
    ctrlLoad = 1'b1; ctrlIn = v;
    @(negedge clk);
    ctrlLoad = 1'b0;
    ctrlModel = v;
  endtask

  // drives one strobe; leaves addrValid high so back-to-back calls chain
  task automatic sendFrame(input logic [47:0] d, input logic [15:0] len, input string tag);
    logic [1:0] e;
    @(negedge clk);
    e = model(d, len);
    qAcc.push_back(e[1]); qPass.push_back(e[0]); qTag.push_back(tag);
    addrValid = 1'b1; destAddr = d; frameLen = len;
    sent++;
  endtask

  task automatic idle();
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic binOnly(input logic [47:0] d, input bit other);
    logic [5:0] h;
    h = benchHash(d);
    if (other) h = h ^ 6'h01;
    hashHi = '0; hashLo = '0;
    if (h[5]) hashHi[h[4:0]] = 1'b1; else hashLo[h[4:0]] = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(ClkPeriod/4);
      if (rstN && acceptValid) begin
        seen++;
        if (qAcc.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected result actual=1 expected=0");
        end else begin
          logic ea, ep;
          string t;
          ea = qAcc.pop_front(); ep = qPass.pop_front(); t = qTag.pop_front();
          check(t, accept, ea, "accept");
          check(t, filterPass, ep, "filterPass");
        end
      end
    end
  end

  bit finished = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [47:0] other = {8'h66, 8'h77, 8'h88, 8'h99, 8'hAA, 8'h04};
  logic [47:0] mcA   = {8'h01, 8'h00, 8'h5E, 8'h12, 8'h34, 8'h01};
  logic [47:0] mcB   = {8'hFE, 8'hDC, 8'hBA, 8'h98, 8'h76, 8'h33};
  logic [47:0] bcast = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    check("R2", acceptValid, 1'b0, "acceptValid in reset");
    check("R2", accept, 1'b0, "accept in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R2", acceptValid, 1'b0, "acceptValid after reset");
    // R2: reset control word -> promiscuous but disabled
    sendFrame(stationAddr, 16'd64, "R2 reset ctrl");
    idle();

    loadCtrl(BRxEn | BProm);
    sendFrame(other, 16'd64, "R5 promisc unicast");
    sendFrame(mcB, 16'd64, "R5 promisc multicast");
    sendFrame(other, 16'd13, "R4 len 13");
    sendFrame(other, 16'd14, "R4 len 14");
    sendFrame(other, 16'd2047, "R4 len 2047");
    sendFrame(other, 16'd2048, "R4 len 2048");
    idle();
    loadCtrl(BRxEn | BRxAll);
    sendFrame(other, 16'd2048, "R4 rxall long");
    sendFrame(other, 16'd100, "R11 rxall fail kept");
    sendFrame(stationAddr, 16'd100, "R11 rxall match");
    idle();
    loadCtrl(BRxAll | BProm);
    sendFrame(other, 16'd64, "R3 disabled with rxall");
    idle();

    loadCtrl(BRxEn);
    sendFrame(stationAddr, 16'd64, "R8 unicast exact hit");
    sendFrame(other, 16'd64, "R8 unicast exact miss");
    sendFrame(bcast, 16'd64, "R6 bcast accepted");
    sendFrame(mcA, 16'd64, "R7 multicast no pass");
    idle();
    loadCtrl(BRxEn | BBcDis | BMcPass);
    sendFrame(bcast, 16'd64, "R6 bcast disabled over mcpass");
    sendFrame(mcA, 16'd64, "R7 mcpass multicast");
    sendFrame(other, 16'd64, "R7 mcpass unicast miss");
    idle();

    // R8 multicast exact match
    loadCtrl(BRxEn);
    stationAddr = mcA;
    sendFrame(mcA, 16'd64, "R8 multicast exact hit");
    idle();
    stationAddr = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};

    loadCtrl(BRxEn | BInv);
    sendFrame(stationAddr, 16'd64, "R9 inverted hit");
    sendFrame(other, 16'd64, "R9 inverted miss");
    idle();

    // R10 unicast hashing
    loadCtrl(BRxEn | BHashUc);
    binOnly(other, 1'b0);
    sendFrame(other, 16'd64, "R10 uc bin set");
    idle();
    binOnly(other, 1'b1);
    sendFrame(other, 16'd64, "R10 uc neighbour bin");
    sendFrame(stationAddr, 16'd64, "R10 uc station not exact");
    sendFrame(mcA, 16'd64, "R8 mc stays exact");
    idle();
    loadCtrl(BRxEn | BHashUc | BInv);
    binOnly(other, 1'b0);
    sendFrame(other, 16'd64, "R9 invert ignores hash");
    idle();

    // R10 multicast hashing, both registers
    loadCtrl(BRxEn | BHashMc);
    binOnly(mcA, 1'b0);
    sendFrame(mcA, 16'd64, "R10 mc bin set");
    idle();
    binOnly(mcB, 1'b0);
    sendFrame(mcB, 16'd64, "R10 mc other bin set");
    sendFrame(mcA, 16'd64, "R10 mc bin clear");
    sendFrame(stationAddr, 16'd64, "R8 uc stays exact");
    idle();
    hashHi = '1; hashLo = '0;
    sendFrame(mcA, 16'd64, "R10 hi only A");
    sendFrame(mcB, 16'd64, "R10 hi only B");
    idle();
    hashHi = '0; hashLo = '1;
    sendFrame(mcA, 16'd64, "R10 lo only A");
    sendFrame(mcB, 16'd64, "R10 lo only B");
    idle();

    // R1 back-to-back strobes
    loadCtrl(BRxEn);
    for (int i = 0; i < 6; i++)
      sendFrame((i % 2) ? stationAddr : other, 16'd64, "R1 back to back");
    idle();
    repeat (4) @(negedge clk);
    check("R1", (seen == sent), 1'b1, "result count equals strobe count");
    check("R1", (qAcc.size() == 0), 1'b1, "no pending results");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule